// File: doc/BRIEF.md
# Fractional M/N:D Clock Divider with Complemented N and D Fields

The block derives a slower rate from its input clock by a fraction M/N, with M no larger than N. Each input cycle an accumulator is advanced by M and folded back whenever it reaches N. Every fold produces a one-cycle enable pulse on `tick_o`, so the pulses average to the input rate times M/N. A second output, `pulse_o`, is a duty-shaped waveform. It is high while twice the accumulator is below the decoded duty value D, so D equal to N gives half duty.

Software-facing values reach the block in a packed form. The M field is taken as is. The N field holds the bitwise complement of (N − M). The D field holds the bitwise complement of D. The block decodes all three before use. Counting runs only in dual-edge mode. In every other mode, and whenever the decoded N does not exceed M, the block is transparent: both outputs stay high on every cycle, so downstream gating sees the full input rate. New field values are accepted only when the accumulator folds, or at once while the block is transparent. This keeps runt pulses off the outputs.

Top module: `mnd_frac_div`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `tick_o` and `pulse_o` are both 1.
- R2: Decoding: the effective M equals `cfg_m_i`. The effective N equals (~`cfg_n_i` masked to CNT_W bits) + M, computed without overflow. The effective D equals ~`cfg_d_i` masked to CNT_W bits.
- R3: While counting, the accumulator adds M on each input cycle. When the sum reaches N or more, N is subtracted and `tick_o` is 1 for that one cycle. Over any whole number of N-cycle periods, the count of `tick_o` cycles is M per period.
- R4: While counting, `pulse_o` is 1 exactly when 2 × accumulator < D. With M=1, D=N gives N/2 high cycles per period, and D=0 keeps `pulse_o` at 0.
- R5: Counting runs only when `cfg_mode_i` equals 2 (dual edge). For mode values 0, 1 and 3 the block is transparent, with `tick_o`=1 and `pulse_o`=1 on every cycle.
- R6: When the decoded N is not greater than M, the block is transparent in any mode. This covers M=N and covers N=0, which arises from M=0 with an N field of all ones.
- R7: While counting, the decoded M, N, D and mode are taken only in the cycle where the accumulator folds. Changes to the fields at other times have no effect until that fold.
- R8: At a fold, the remainder is kept in the accumulator when it is below the newly taken N. Otherwise the accumulator restarts at 0. When the block leaves transparency, the accumulator starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_m_i | input | CNT_W | M value, plain |
| cfg_n_i | input | CNT_W | Complement of (N − M) |
| cfg_d_i | input | CNT_W | Complement of the duty value D |
| cfg_mode_i | input | 2 | Divider mode; 2 selects counting |
| tick_o | output | 1 | One-cycle enable per accumulator fold, or constant 1 when transparent |
| pulse_o | output | 1 | Duty-shaped divided clock, or constant 1 when transparent |

## Verification
Two functions can fall in the same cycle: an accumulator fold and the acceptance of new field values. The remainder of the old fold must then be judged against the newly taken N. The bench provokes this in two ways. First, it changes N in the very cycle a tick is seen and measures that the next gap still follows the old N and the gap after it follows the new N. Second, it makes a long run of random field changes that often land on fold cycles and often leave a remainder at or above the new N. A behavioural model with plain integers predicts both outputs, and the bench compares them with the design on every cycle.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
package fdiv_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_RSV1  = 2'd1,
        MODE_DUAL  = 2'd2,
        MODE_RSV3  = 2'd3
    } fdiv_mode_e;
endpackage

// File: rtl/fdiv_decode.sv
`timescale 1ns/1ps
// Unpacks the complemented N and D fields and judges whether counting is legal.
module fdiv_decode #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] m_raw_i,
    input  logic [CNT_W-1:0] n_raw_i,
    input  logic [CNT_W-1:0] d_raw_i,
    input  logic [1:0]       mode_i,
    output logic [CNT_W-1:0] m_eff_o,
    output logic [CNT_W:0]   n_eff_o,
    output logic [CNT_W-1:0] d_eff_o,
    output logic             run_ok_o
);
    import fdiv_pkg::*;

    logic [CNT_W:0] m_wide;
    logic [CNT_W:0] span;

    always_comb begin
        m_wide   = {1'b0, m_raw_i};
        span     = {1'b0, ~n_raw_i};
        m_eff_o  = m_raw_i;
        n_eff_o  = span + m_wide;
        d_eff_o  = ~d_raw_i;
        // N must exceed M; this also excludes N == 0
        run_ok_o = (fdiv_mode_e'(mode_i) == MODE_DUAL) && (n_eff_o > m_wide);
    end
endmodule

// File: rtl/fdiv_core.sv
`timescale 1ns/1ps
// Accumulator, shadow configuration and registered outputs.
module fdiv_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] m_eff_i,
    input  logic [CNT_W:0]   n_eff_i,
    input  logic [CNT_W-1:0] d_eff_i,
    input  logic             run_ok_i,
    output logic             run_o,
    output logic [CNT_W:0]   acc_o,
    output logic [CNT_W-1:0] m_o,
    output logic [CNT_W:0]   n_o,
    output logic [CNT_W-1:0] d_o,
    output logic             tick_o,
    output logic             pulse_o
);
    localparam int AW = CNT_W + 1;   // accumulator width, holds values below N
    localparam int SW = AW + 1;      // sum width, holds acc + M

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] m;
        logic [AW-1:0]    n;
        logic [CNT_W-1:0] d;
        logic [AW-1:0]    acc;
        logic             tick;
        logic             pulse;
    } st_t;

    st_t st_d, st_q;

    logic [SW-1:0] sum;
    logic [SW-1:0] rem;
    logic          fold;
    logic          take;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.acc} + {{(SW-CNT_W){1'b0}}, st_q.m};
        rem  = sum - {1'b0, st_q.n};
        fold = 1'b0;
        take = 1'b0;

        if (!st_q.run) begin
            take       = 1'b1;
            st_d.acc   = '0;
        end else if (sum >= {1'b0, st_q.n}) begin
            fold       = 1'b1;
            take       = 1'b1;
            st_d.acc   = rem[AW-1:0];
        end else begin
            st_d.acc   = sum[AW-1:0];
        end

        if (take) begin
            st_d.run = run_ok_i;
            st_d.m   = m_eff_i;
            st_d.n   = n_eff_i;
            st_d.d   = d_eff_i;
            if (st_d.acc >= n_eff_i) begin
                st_d.acc = '0;
            end
        end

        if (!st_d.run) begin
            st_d.acc   = '0;
            st_d.tick  = 1'b1;
            st_d.pulse = 1'b1;
        end else begin
            st_d.tick  = fold;
            st_d.pulse = ({st_d.acc, 1'b0} < {2'b00, st_d.d});
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.tick  <= 1'b1;
            st_q.pulse <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o   = st_q.run;
    assign acc_o   = st_q.acc;
    assign m_o     = st_q.m;
    assign n_o     = st_q.n;
    assign d_o     = st_q.d;
    assign tick_o  = st_q.tick;
    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/mnd_frac_div.sv
`timescale 1ns/1ps
module mnd_frac_div #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cfg_m_i,
    input  logic [CNT_W-1:0] cfg_n_i,
    input  logic [CNT_W-1:0] cfg_d_i,
    input  logic [1:0]       cfg_mode_i,
    output logic             tick_o,
    output logic             pulse_o
);
    logic [CNT_W-1:0] m_eff;
    logic [CNT_W:0]   n_eff;
    logic [CNT_W-1:0] d_eff;
    logic             run_ok;

    logic             run_w;
    logic [CNT_W:0]   acc_w;
    logic [CNT_W-1:0] m_w;
    logic [CNT_W:0]   n_w;
    logic [CNT_W-1:0] d_w;

    fdiv_decode #(.CNT_W(CNT_W)) u_dec (
        .m_raw_i  (cfg_m_i),
        .n_raw_i  (cfg_n_i),
        .d_raw_i  (cfg_d_i),
        .mode_i   (cfg_mode_i),
        .m_eff_o  (m_eff),
        .n_eff_o  (n_eff),
        .d_eff_o  (d_eff),
        .run_ok_o (run_ok)
    );

    fdiv_core #(.CNT_W(CNT_W)) u_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .m_eff_i  (m_eff),
        .n_eff_i  (n_eff),
        .d_eff_i  (d_eff),
        .run_ok_i (run_ok),
        .run_o    (run_w),
        .acc_o    (acc_w),
        .m_o      (m_w),
        .n_o      (n_w),
        .d_o      (d_w),
        .tick_o   (tick_o),
        .pulse_o  (pulse_o)
    );
endmodule

// File: rtl/fdiv_chk.sv
`timescale 1ns/1ps
module fdiv_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run,
    input logic [CNT_W:0]   acc,
    input logic [CNT_W-1:0] m,
    input logic [CNT_W:0]   n,
    input logic [CNT_W-1:0] d,
    input logic             tick,
    input logic             pulse
);
    // R5
    idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run |-> (tick && pulse));

    // R3
    acc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run |-> (acc < n));

    // R6
    ratio_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run |-> ({1'b0, m} < n));

    // R7
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && $past(run) && !tick) |-> ($stable(m) && $stable(n) && $stable(d)));

    // R4
    zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && d == '0) |-> !pulse);
endmodule

bind mnd_frac_div fdiv_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run    (run_w),
    .acc    (acc_w),
    .m      (m_w),
    .n      (n_w),
    .d      (d_w),
    .tick   (tick_o),
    .pulse  (pulse_o)
);

// File: tb/tb_mnd_frac_div.sv
`timescale 1ns/1ps
module tb_mnd_frac_div;
    localparam int W    = 8;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] m_in = '0;
    logic [W-1:0] n_in = '0;
    logic [W-1:0] d_in = '0;
    logic [1:0]   mode_in = 2'd0;
    logic         tick_o, pulse_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    mnd_frac_div #(.CNT_W(W)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_m_i(m_in), .cfg_n_i(n_in), .cfg_d_i(d_in), .cfg_mode_i(mode_in),
        .tick_o(tick_o), .pulse_o(pulse_o)
    );

    // behavioural reference model
    int  r_acc, r_m, r_n, r_d;
    bit  r_run, r_tick, r_pulse;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_run = 0; r_acc = 0; r_m = 0; r_n = 0; r_d = 0;
            r_tick = 1; r_pulse = 1;
        end else begin
            int  mm, nn, dd, s;
            bit  ok, wrapped, accept;
            mm = int'(m_in);
            nn = (int'(~n_in) & MASK) + mm;
            dd = int'(~d_in) & MASK;
            ok = (mode_in == 2'd2) && (nn > mm);
            wrapped = 0;
            accept = 0;
            if (!r_run) begin
                accept = 1;
                r_acc = 0;
            end else begin
                s = r_acc + r_m;
                if (s >= r_n) begin
                    wrapped = 1;
                    accept = 1;
                    r_acc = s - r_n;
                end else begin
                    r_acc = s;
                end
            end
            if (accept) begin
                r_run = ok; r_m = mm; r_n = nn; r_d = dd;
                if (r_acc >= nn) r_acc = 0;
            end
            if (!r_run) begin
                r_acc = 0; r_tick = 1; r_pulse = 1;
            end else begin
                r_tick = wrapped;
                r_pulse = (2 * r_acc < r_d);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // per-cycle comparison against the model (R3, R4, R7, R8)
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check("R3 tick vs model", int'(tick_o), int'(r_tick));
            check("R4 pulse vs model", int'(pulse_o), int'(r_pulse));
        end
    end

    task automatic set_cfg(input int m, input int n, input int d, input int mode);
        m_in    = W'(m);
        n_in    = W'(~(n - m) & MASK);
        d_in    = W'(~d & MASK);
        mode_in = 2'(mode);
    endtask

    task automatic window(input int len, output int ticks, output int highs);
        ticks = 0; highs = 0;
        repeat (len) begin
            @(negedge clk);
            ticks += int'(tick_o);
            highs += int'(pulse_o);
        end
    endtask

    task automatic gap(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!tick_o);
    endtask

    initial begin
        int t, h, g;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 tick in reset", int'(tick_o), 1);
        check("R1 pulse in reset", int'(pulse_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tick after reset", int'(tick_o), 1);
        check("R1 pulse after reset", int'(pulse_o), 1);

        // R2 decode: M=1, N=4 -> one tick every 4 cycles
        set_cfg(1, 4, 4, 2);
        repeat (30) @(negedge clk);
        window(40, t, h);
        check("R2 ticks M=1 N=4", t, 10);
        check("R2 highs M=1 N=4 D=4", h, 20);

        // R3 fractional rate M=3, N=8
        set_cfg(3, 8, 8, 2);
        repeat (30) @(negedge clk);
        window(80, t, h);
        check("R3 ticks M=3 N=8", t, 30);

        // R4 duty: D=N half duty, D=0 never high
        set_cfg(1, 8, 8, 2);
        repeat (30) @(negedge clk);
        window(80, t, h);
        check("R4 highs D=N", h, 40);
        set_cfg(1, 8, 0, 2);
        repeat (30) @(negedge clk);
        window(80, t, h);
        check("R4 highs D=0", h, 0);
        check("R4 ticks D=0", t, 10);

        // R5 non-dual mode is transparent
        set_cfg(1, 8, 4, 1);
        repeat (30) @(negedge clk);
        window(20, t, h);
        check("R5 ticks mode 1", t, 20);
        check("R5 highs mode 1", h, 20);

        // R6 M equal to N, and N zero
        set_cfg(5, 5, 3, 2);
        repeat (20) @(negedge clk);
        window(20, t, h);
        check("R6 ticks M=N", t, 20);
        m_in = '0; n_in = W'(MASK); d_in = '0; mode_in = 2'd2;
        repeat (5) @(negedge clk);
        window(20, t, h);
        check("R6 highs N=0", h, 20);

        // R7 change on a fold cycle: old period finishes, then new one
        set_cfg(1, 10, 10, 2);
        repeat (30) @(negedge clk);
        gap(g);
        set_cfg(1, 3, 3, 2);
        gap(g);
        check("R7 gap under old N", g, 10);
        gap(g);
        check("R7 gap under new N", g, 3);

        // R8 remainder against a smaller new N: M=5 N=7 then M=1 N=2
        for (int k = 0; k < 6; k++) begin
            set_cfg(5, 7, 7, 2);
            repeat (7 + k) @(negedge clk);
            set_cfg(1, 2, 2, 2);
            repeat (5) @(negedge clk);
        end

        // random field changes, model compared each cycle
        for (int k = 0; k < 300; k++) begin
            int mm, nn, md;
            mm = $urandom_range(0, 20);
            nn = mm + $urandom_range(0, 20);
            md = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3) : 2;
            set_cfg(mm, nn, $urandom_range(0, 2 * nn + 1), md);
            repeat ($urandom_range(1, 25)) @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule